// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synchronous, device-side model of a 2-kilobit serial nonvolatile memory driven over a three-wire link. A master drives a select line, a serial clock and a serial data input. The block returns serial data and a separate output-enable that stands in for a tri-state pin. All serial inputs are sampled by the system clock `clk_i`. A rising serial-clock edge is detected as a 0-to-1 change of `sclk_i` between two system clocks.

An instruction is a start bit, a two-bit opcode and an address field. A write then carries its data bits. A read returns a dummy zero and then the data word, most significant bit first. A strap selects either 256 words of 8 bits or 128 words of 16 bits. Write and erase operations are guarded by an enable latch. They are followed by a self-timed busy period that runs on system clocks alone. While that period runs, a master that deselects and reselects the part sees the ready/busy status on the data output.

Top module: `mw_eeprom_slave`

## Requirements
- R1: With `org16_i`=0 the array is 256 x 8 and takes a 9-bit address whose MSB is ignored. With `org16_i`=1 it is 128 x 16 and takes an 8-bit address whose MSB is ignored. In the 16-bit organisation, word n occupies byte 2n as its high half and byte 2n+1 as its low half.
- R2: While `cs_i` is low, the serial control returns to its start-waiting state within one system clock. `do_oe_o` is low, and `sclk_i` and `di_i` have no effect. An instruction cut short by a low `cs_i` leaves no trace.
- R3: With `cs_i` high and no start bit yet seen, any number of rising serial-clock edges with `di_i`=0 leave the block waiting and `do_oe_o` low. A start bit is a rising edge with `di_i`=1.
- R4: Input bits are taken on rising serial-clock edges. The read output changes only on rising edges and holds while `sclk_i` stays low.
- R5: Opcode 10 reads. On the edge of the last address bit, `do_o` is driven with a dummy 0. Each of the next 8 (or 16) rising edges presents the next data bit, MSB first. The edge after the last data bit releases `do_oe_o`.
- R6: Opcode 01 writes. The data bits (8 or 16, MSB first) follow the address. The word is written on the edge of the last data bit, and only if writes are enabled.
- R7: Opcode 11 erases the addressed word to all ones, and only if writes are enabled.
- R8: Opcode 00 uses the top two address-field bits. 11 enables writes, 00 disables them, 10 erases the whole array to ones, and 01 writes the data word that follows to every location. After reset, writes are disabled.
- R9: A write or erase starts a busy period of `BUSY_CYCLES` system clocks. It needs no serial clock and finishes even if `cs_i` goes low.
- R10: After a write or erase has started, a low-to-high change of `cs_i` drives `do_o` with 0 while busy and 1 once ready. If `cs_i` stays high from the instruction onward, `do_oe_o` stays low. The next start bit ends the status display.
- R11: Start bits received while busy are ignored, and the status display continues.
- R12: Once an instruction has completed, further edges (including ones with `di_i`=1) are ignored until `cs_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from master |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organisation strap: 1 = 128 x 16, 0 = 256 x 8 |
| do_o | output | 1 | Serial data / ready-busy out |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |

## Verification
The hardest case to reach is a start bit arriving during the self-timed period, because at that moment the block must keep showing status instead of beginning a read. The bench sets a long busy period through the parameter. It issues a write, toggles select, and then clocks in a complete read instruction and its data edges while the busy period is still running. A read would put a data word with a leading one on the output. The expected result is `do_o` holding at 0, and after that the bench waits for the output to change to ready.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_WDATA, ST_READ, ST_DONE} mw_state_e;
  typedef enum logic [1:0] {PG_WORD_WR, PG_WORD_ER, PG_ALL_WR, PG_ALL_ER} pgm_kind_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/mw_store.sv
module mw_store
  import mw_eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int BUSY_CYCLES = 20,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int BCW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          org16_i,
  input  logic          launch_i,
  input  pgm_kind_e     kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          busy_o
);
  logic [7:0]     mem_q [MEM_BYTES];
  logic [BCW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
    end else if (launch_i) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (kind_i == PG_ALL_WR || kind_i == PG_ALL_ER ||
            (org16_i ? (addr_i[AW-2:0] == (AW-1)'(i >> 1)) : (addr_i == AW'(i)))) begin
          if (kind_i == PG_WORD_ER || kind_i == PG_ALL_ER) mem_q[i] <= 8'hFF;
          else if (org16_i)                                mem_q[i] <= (i % 2 == 0) ? wdata_i[15:8] : wdata_i[7:0];
          else                                             mem_q[i] <= wdata_i[7:0];
        end
      end
    end
  end

  assign rdata_o = org16_i ? {mem_q[{addr_i[AW-2:0], 1'b0}], mem_q[{addr_i[AW-2:0], 1'b1}]}
                           : {8'h00, mem_q[addr_i]};

  // self-timed period: system clocks only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (launch_i)          tmr_q <= BCW'(BUSY_CYCLES);
    else if (tmr_q != '0)       tmr_q <= tmr_q - 1'b1;
  end
  assign busy_o = (tmr_q != '0);

  assert_launch_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o);
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int HDR_W = AW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          di_i,
  input  logic          org16_i,
  input  logic          busy_i,
  input  logic [15:0]   rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          launch_o,
  output pgm_kind_e     kind_o,
  output logic [15:0]   wdata_o,
  output logic          do_o,
  output logic          do_oe_o
);
  mw_state_e       st_q;
  logic            sclk_q, cs_q, rise;
  logic [4:0]      cnt_q, hdr_last, dat_last;
  logic [HDR_W-1:0] hdr_q, hdr_nx;
  logic [15:0]     wd_q, wd_nx, sh_q, rd_al;
  logic [1:0]      op, ext;
  logic [AW-1:0]   waddr;
  logic            wen_q, stat_arm_q, stat_show_q, out_q;

  assign rise     = cs_i & sclk_i & ~sclk_q;
  assign hdr_last = org16_i ? 5'(AW + 1) : 5'(AW + 2);
  assign dat_last = org16_i ? 5'd15 : 5'd7;
  assign hdr_nx   = {hdr_q[HDR_W-2:0], di_i};
  assign wd_nx    = {wd_q[14:0], di_i};
  assign op       = org16_i ? hdr_nx[AW+1:AW] : hdr_nx[AW+2:AW+1];
  assign ext      = org16_i ? hdr_nx[AW-1:AW-2] : hdr_nx[AW:AW-1];
  assign waddr    = org16_i ? {1'b0, hdr_nx[AW-2:0]} : hdr_nx[AW-1:0];
  assign rd_al    = org16_i ? rdata_i : {rdata_i[7:0], 8'h00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sclk_q <= 1'b0; cs_q <= 1'b0; cnt_q <= '0;
      hdr_q <= '0; wd_q <= '0; sh_q <= '0; out_q <= 1'b0;
      wen_q <= 1'b0; stat_arm_q <= 1'b0; stat_show_q <= 1'b0;
      addr_o <= '0; launch_o <= 1'b0; kind_o <= PG_WORD_WR; wdata_o <= '0;
    end else begin
      sclk_q   <= sclk_i;
      cs_q     <= cs_i;
      launch_o <= 1'b0;
      if (!cs_i) begin
        st_q <= ST_IDLE; stat_show_q <= 1'b0; out_q <= 1'b0;
      end else begin
        if (!cs_q) stat_show_q <= stat_arm_q;
        if (rise) begin
          unique case (st_q)
            ST_IDLE: if (di_i && !busy_i) begin
              st_q <= ST_HDR; cnt_q <= '0; hdr_q <= '0;
              stat_show_q <= 1'b0; stat_arm_q <= 1'b0;
            end
            ST_HDR: begin
              hdr_q <= hdr_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == hdr_last) begin
                addr_o <= waddr; cnt_q <= '0; wd_q <= '0;
                unique case (op)
                  OP_READ:  begin st_q <= ST_READ; out_q <= 1'b0; end
                  OP_WRITE: begin st_q <= ST_WDATA; kind_o <= PG_WORD_WR; end
                  OP_ERASE: begin
                    st_q <= ST_DONE; kind_o <= PG_WORD_ER;
                    launch_o <= wen_q; stat_arm_q <= wen_q;
                  end
                  default: begin
                    st_q <= ST_DONE;
                    unique case (ext)
                      EXT_EN:   wen_q <= 1'b1;
                      EXT_DIS:  wen_q <= 1'b0;
                      EXT_ERAL: begin kind_o <= PG_ALL_ER; launch_o <= wen_q; stat_arm_q <= wen_q; end
                      default:  begin kind_o <= PG_ALL_WR; st_q <= ST_WDATA; end
                    endcase
                  end
                endcase
              end
            end
            ST_WDATA: begin
              wd_q  <= wd_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == dat_last) begin
                wdata_o    <= org16_i ? wd_nx : {8'h00, wd_nx[7:0]};
                launch_o   <= wen_q;
                stat_arm_q <= wen_q;
                st_q       <= ST_DONE;
              end
            end
            ST_READ: begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == '0) begin
                out_q <= rd_al[15]; sh_q <= {rd_al[14:0], 1'b0};
              end else if (cnt_q == dat_last + 5'd1) begin
                st_q <= ST_DONE;
              end else begin
                out_q <= sh_q[15]; sh_q <= {sh_q[14:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign do_oe_o = cs_i & ((st_q == ST_READ) | (stat_show_q & (st_q == ST_IDLE)));
  assign do_o    = (st_q == ST_READ) ? out_q : ~busy_i;

  assert_deselect_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> st_q == ST_IDLE);
  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && rise && !di_i) |=> st_q == ST_IDLE);
  assert_busy_no_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && st_q == ST_IDLE) |=> st_q != ST_HDR);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int BUSY_CYCLES = 20,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org16_i,
  output logic do_o,
  output logic do_oe_o
);
  logic          busy, launch;
  pgm_kind_e     kind;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, rdata;

  mw_ctrl #(.MEM_BYTES(MEM_BYTES)) i_ctrl (
    .clk_i, .rst_ni, .cs_i, .sclk_i, .di_i, .org16_i,
    .busy_i(busy), .rdata_i(rdata), .addr_o(addr), .launch_o(launch),
    .kind_o(kind), .wdata_o(wdata), .do_o, .do_oe_o
  );

  mw_store #(.MEM_BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) i_store (
    .clk_i, .rst_ni, .org16_i, .launch_i(launch), .kind_i(kind),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  assert_status_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && cs_i) |=> !do_oe_o);
endmodule

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 120;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, di = 0, org16 = 0;
  logic dout, doe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  mw_eeprom_slave #(.MEM_BYTES(256), .BUSY_CYCLES(BUSY)) i_mw_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org16_i(org16), .do_o(dout), .do_oe_o(doe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // org, 9-bit address, data
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 9'h000, 16'h00A5}, {1'b0, 9'h0FF, 16'h003C}, {1'b0, 9'h081, 16'h0001},
    {1'b1, 9'h000, 16'h1234}, {1'b1, 9'h07F, 16'hFFFE}, {1'b1, 9'h042, 16'h8001}};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    @(negedge clk) di = b; sclk = 0;
    @(negedge clk) sclk = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) cs = 0; sclk = 0; di = 0;
    repeat (2) @(negedge clk);
    cs = 1;
    @(negedge clk);
  endtask

  task automatic hdr(logic [1:0] op, logic [8:0] a);
    int ab = org16 ? 8 : 9;
    sbit(1); sbit(op[1]); sbit(op[0]);
    for (int k = ab - 1; k >= 0; k--) sbit(a[k]);
  endtask

  task automatic ext_cmd(logic [1:0] e);
    desel();
    hdr(2'b00, org16 ? {1'b0, e, 6'h0} : {e, 7'h0});
  endtask

  task automatic data_bits(logic [15:0] d);
    int dl = org16 ? 16 : 8;
    for (int k = dl - 1; k >= 0; k--) sbit(d[k]);
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    desel(); hdr(2'b01, a); data_bits(d);
  endtask

  task automatic settle();
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] q);
    int dl = org16 ? 16 : 8;
    q = '0;
    desel(); hdr(2'b10, a);
    check("R5 dummy oe", {15'h0, doe}, 16'h1);
    check("R5 dummy bit", {15'h0, dout}, 16'h0);
    for (int k = 0; k < dl; k++) begin
      sbit(0);
      q = {q[14:0], dout};
    end
    sbit(0);
    check("R5 release", {15'h0, doe}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] q, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset oe", {15'h0, doe}, 16'h0);

    // table walk: R1 R6
    for (int v = 0; v < 6; v++) begin
      org16 = VEC[v][25];
      ext_cmd(2'b11);
      wr(VEC[v][24:16], VEC[v][15:0]);
      settle();
      rd(VEC[v][24:16], q);
      exp = org16 ? VEC[v][15:0] : {8'h00, VEC[v][7:0]};
      check("R6 R1 table", q, exp);
    end

    // R1: ignored address MSB and byte mapping
    org16 = 0; ext_cmd(2'b11);
    wr(9'h105, 16'h003C); settle();
    rd(9'h005, q); check("R1 x8 msb ignored", q, 16'h003C);
    org16 = 1; ext_cmd(2'b11);
    wr(9'h085, 16'hBEEF); settle();
    rd(9'h005, q); check("R1 x16 msb ignored", q, 16'hBEEF);
    org16 = 0;
    rd(9'h00A, q); check("R1 high byte", q, 16'h00BE);
    rd(9'h00B, q); check("R1 low byte", q, 16'h00EF);

    // R3: idle edges then read
    desel();
    for (int k = 0; k < 10; k++) sbit(0);
    check("R3 idle oe", {15'h0, doe}, 16'h0);
    hdr(2'b10, 9'h00B);
    check("R3 start after idle", {15'h0, doe}, 16'h1);

    // R2: abort mid instruction, edges while deselected
    desel(); sbit(1); sbit(0); sbit(1); sbit(1);
    @(negedge clk) cs = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) di = 1; sclk = 1;
      @(negedge clk) sclk = 0;
    end
    check("R2 deselected oe", {15'h0, doe}, 16'h0);
    rd(9'h00B, q); check("R2 clean after abort", q, 16'h00EF);

    // R4: output holds while sclk low
    desel(); hdr(2'b10, 9'h00A); sbit(0);
    @(negedge clk) sclk = 0; di = 1;
    repeat (3) @(negedge clk);
    check("R4 hold on low clock", {15'h0, dout}, 16'h1);

    // R6: disabled write ignored
    org16 = 0; ext_cmd(2'b11); wr(9'h010, 16'h0011); settle();
    ext_cmd(2'b00); wr(9'h010, 16'h0077); settle();
    rd(9'h010, q); check("R6 write disabled", q, 16'h0011);

    // R7: erase word
    ext_cmd(2'b11); desel(); hdr(2'b11, 9'h010); settle();
    rd(9'h010, q); check("R7 erase word", q, 16'h00FF);
    rd(9'h011, q); check("R7 neighbour kept", q, 16'h0000);

    // R8: erase all, write all
    ext_cmd(2'b10); settle();
    org16 = 1; rd(9'h003, q); check("R8 erase all", q, 16'hFFFF);
    ext_cmd(2'b01); data_bits(16'h5A5A); settle();
    org16 = 0; rd(9'h007, q); check("R8 write all", q, 16'h005A);
    rd(9'h0F0, q); check("R8 write all far", q, 16'h005A);

    // R10: status display
    wr(9'h020, 16'h00C3);
    check("R10 no status without reselect", {15'h0, doe}, 16'h0);
    desel();
    check("R10 status oe", {15'h0, doe}, 16'h1);
    check("R10 busy low", {15'h0, dout}, 16'h0);
    // R11: full read instruction during busy is ignored (addr 0x20 holds C3, MSB 1)
    hdr(2'b10, 9'h020); sbit(0);
    check("R11 start ignored oe", {15'h0, doe}, 16'h1);
    check("R11 start ignored do", {15'h0, dout}, 16'h0);
    settle();
    check("R10 ready high", {15'h0, dout}, 16'h1);
    rd(9'h020, q); check("R6 status write data", q, 16'h00C3);

    // R9: cycle completes with cs held low
    wr(9'h021, 16'h0096);
    @(negedge clk) cs = 0;
    repeat (BUSY + 10) @(negedge clk);
    cs = 1;
    @(negedge clk);
    check("R9 ready after low select", {14'h0, doe, dout}, 16'h3);
    rd(9'h021, q); check("R9 data kept", q, 16'h0096);

    // R12: edges after completed read ignored
    rd(9'h020, q);
    sbit(1); sbit(1); sbit(0);
    for (int k = 0; k < 9; k++) sbit(0);
    check("R12 after done", {15'h0, doe}, 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule